// File: doc/BRIEF.md
# Cascadable Decimal Up/Down Digit Counter

The block counts in decimal, one digit at a time, on a single system clock. Each digit stage holds a value in 4-bit BCD. It steps up on a rising edge of its up strobe and down on a rising edge of its down strobe. A synchronous clear (active high) and a parallel load (active low) can override the count. Each stage produces a one-cycle carry pulse when it wraps upward and a one-cycle borrow pulse when it wraps downward. The next stage up uses these pulses as its strobes.

The top level chains two digit stages into a tens/units pair. It returns the pair to 00 at the clock edge where the pair would otherwise take the programmed terminal value (60 by default), so the terminal value never reaches the outputs. Because the carry and borrow pulses are registered, the tens digit follows the units digit one cycle later, in the same way as chained discrete counters.

Top module: `bcd_pair_counter`

## Requirements
- R1: While `rst` is high at a clock edge, both digits become 0 and `carry_out` and `borrow_out` go low.
- R2: A rising edge of `up_req` (low in one cycle, high in the next) increments the units digit at that edge. An increment from 9 gives 0 and raises the stage carry for exactly one cycle.
- R3: A rising edge of `dn_req` decrements the units digit. A decrement from 0 gives 9 and raises the stage borrow for exactly one cycle.
- R4: If both strobes rise in the same cycle, the digit holds. A strobe held high causes no further steps.
- R5: While `load_n` is low, the units digit takes `load_units` and the tens digit takes `load_tens` at the clock edge. A load overrides counting in the same cycle.
- R6: While `clr` is high, both digits become 0 at the clock edge. Clear overrides load.
- R7: The units carry increments the tens digit and the units borrow decrements it. The tens digit moves one cycle after the units digit wraps.
- R8: A digit holding a value above 9 goes to 0 with carry on increment, and drops by one on decrement.
- R9: When the next pair value, from counting or from a load, would equal the terminal value (the parameter `TERMINAL`, default 60), both digits become 0 instead. The terminal value never appears on `tens`/`units`.
- R10: `carry_out` pulses for one cycle when the tens digit wraps from 9 to 0, and also in the cycle after a terminal reset. `borrow_out` pulses for one cycle when the tens digit wraps from 0 to 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| up_req | input | 1 | Count-up strobe, acted on at its rising edge |
| dn_req | input | 1 | Count-down strobe, acted on at its rising edge |
| load_n | input | 1 | Parallel load enable, active low |
| clr | input | 1 | Synchronous clear, active high |
| load_units | input | 4 | Value loaded into the units digit |
| load_tens | input | 4 | Value loaded into the tens digit |
| units | output | 4 | Units digit, BCD |
| tens | output | 4 | Tens digit, BCD |
| carry_out | output | 1 | One-cycle pulse on tens wrap-up or on terminal reset |
| borrow_out | output | 1 | One-cycle pulse on tens wrap-down |

## Verification
The bench targets the boundaries of the count:
- **59 stepping up.** A design that compared the current value rather than the next value would display 60 for one cycle before clearing.
- **00 stepping down.** It must ripple to 99. A design that got the borrow path wrong would stop at 09 or fail to pulse `borrow_out`.
- **Loaded values above 9.** These must wrap to 0 on increment.
- **Loading 60 directly.** This must yield 00.
- **Conflicting controls in one cycle.** Clear with load, load with a strobe, and both strobes together each test the priority rules. A design with the wrong order would show the loaded or stepped value instead.

// File: rtl/bcd_cnt_pkg.sv
package bcd_cnt_pkg;
  localparam int DIGIT_W = 4;
  localparam int RADIX   = 10;
  typedef logic [DIGIT_W-1:0] digit_t;
endpackage

// File: rtl/strobe_rise.sv
module strobe_rise (
  input  logic clk,
  input  logic rst,
  input  logic sig_i,
  output logic rise_o
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= sig_i;
  end

  assign rise_o = sig_i & ~prev_q;
endmodule

// File: rtl/bcd_digit.sv
module bcd_digit
  import bcd_cnt_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   clr_i,
  input  logic   load_n_i,
  input  digit_t data_i,
  input  logic   up_i,
  input  logic   dn_i,
  input  logic   zero_i,
  output digit_t q_o,
  output digit_t nxt_o,
  output logic   carry_o,
  output logic   borrow_o
);
  localparam digit_t MAXD = digit_t'(RADIX - 1);

  logic   up_r, dn_r;
  logic   wrap_up, wrap_dn;
  digit_t nxt;

  strobe_rise up_edge_i (.clk(clk), .rst(rst), .sig_i(up_i), .rise_o(up_r));
  strobe_rise dn_edge_i (.clk(clk), .rst(rst), .sig_i(dn_i), .rise_o(dn_r));

  always_comb begin
    nxt     = q_o;
    wrap_up = 1'b0;
    wrap_dn = 1'b0;
    if (clr_i) begin
      nxt = '0;
    end else if (!load_n_i) begin
      nxt = data_i;
    end else if (up_r && !dn_r) begin
      if (q_o >= MAXD) begin
        nxt     = '0;
        wrap_up = 1'b1;
      end else begin
        nxt = q_o + digit_t'(1);
      end
    end else if (dn_r && !up_r) begin
      if (q_o == '0) begin
        nxt     = MAXD;
        wrap_dn = 1'b1;
      end else begin
        nxt = q_o - digit_t'(1);
      end
    end
  end

  assign nxt_o = nxt;

  always_ff @(posedge clk) begin
    if (rst) begin
      q_o      <= '0;
      carry_o  <= 1'b0;
      borrow_o <= 1'b0;
    end else begin
      q_o      <= zero_i ? '0 : nxt;
      carry_o  <= wrap_up & ~zero_i;
      borrow_o <= wrap_dn & ~zero_i;
    end
  end

  // clear wins over everything else (R6)
  assert_clear_R6: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> (q_o == '0));

  // load lands unless the terminal reset overrides it (R5)
  assert_load_R5: assert property (@(posedge clk) disable iff (rst)
    (!clr_i && !load_n_i && !zero_i) |=> (q_o == $past(data_i)));

  // an upward wrap leaves the digit at zero for a single pulse (R2)
  assert_carry_wrap_R2: assert property (@(posedge clk) disable iff (rst)
    carry_o |-> (q_o == '0));
  assert_carry_single_R2: assert property (@(posedge clk) disable iff (rst)
    carry_o |=> !carry_o);

  // a downward wrap leaves the digit at nine (R3)
  assert_borrow_wrap_R3: assert property (@(posedge clk) disable iff (rst)
    borrow_o |-> (q_o == MAXD));
endmodule

// File: rtl/bcd_pair_counter.sv
module bcd_pair_counter
  import bcd_cnt_pkg::*;
#(
  parameter int TERMINAL = 60
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       up_req,
  input  logic       dn_req,
  input  logic       load_n,
  input  logic       clr,
  input  logic [3:0] load_units,
  input  logic [3:0] load_tens,
  output logic [3:0] units,
  output logic [3:0] tens,
  output logic       carry_out,
  output logic       borrow_out
);
  localparam digit_t TERM_U = digit_t'(TERMINAL % RADIX);
  localparam digit_t TERM_T = digit_t'((TERMINAL / RADIX) % RADIX);

  digit_t u_q, u_nxt, t_q, t_nxt;
  logic   u_carry, u_borrow, t_carry, t_borrow;
  logic   term_hit, term_q;

  assign term_hit = (u_nxt == TERM_U) && (t_nxt == TERM_T);

  bcd_digit units_i (
    .clk(clk), .rst(rst), .clr_i(clr), .load_n_i(load_n), .data_i(load_units),
    .up_i(up_req), .dn_i(dn_req), .zero_i(term_hit),
    .q_o(u_q), .nxt_o(u_nxt), .carry_o(u_carry), .borrow_o(u_borrow)
  );

  bcd_digit tens_i (
    .clk(clk), .rst(rst), .clr_i(clr), .load_n_i(load_n), .data_i(load_tens),
    .up_i(u_carry), .dn_i(u_borrow), .zero_i(term_hit),
    .q_o(t_q), .nxt_o(t_nxt), .carry_o(t_carry), .borrow_o(t_borrow)
  );

  always_ff @(posedge clk) begin
    if (rst) term_q <= 1'b0;
    else     term_q <= term_hit;
  end

  assign units      = u_q;
  assign tens       = t_q;
  assign carry_out  = t_carry | term_q;
  assign borrow_out = t_borrow;

  // the terminal value is never visible (R9)
  assert_no_terminal_R9: assert property (@(posedge clk) disable iff (rst)
    !((u_q == TERM_U) && (t_q == TERM_T)));

  // a tens borrow pulse means the tens digit just went to nine (R10)
  assert_borrow_out_R10: assert property (@(posedge clk) disable iff (rst)
    borrow_out |-> (tens == digit_t'(RADIX - 1)));
endmodule

// File: tb/bcd_pair_counter_tb_top.sv
module bcd_pair_counter_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       up_req = 1'b0, dn_req = 1'b0, load_n = 1'b1, clr = 1'b0;
  logic [3:0] load_units = '0, load_tens = '0;
  logic [3:0] units, tens;
  logic       carry_out, borrow_out;

  int total = 0;
  int bad   = 0;
  int carry_cnt = 0, borrow_cnt = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  bcd_pair_counter #(.TERMINAL(60)) dut_i (
    .clk(clk), .rst(rst), .up_req(up_req), .dn_req(dn_req), .load_n(load_n),
    .clr(clr), .load_units(load_units), .load_tens(load_tens),
    .units(units), .tens(tens), .carry_out(carry_out), .borrow_out(borrow_out)
  );

  always @(negedge clk) begin
    if (carry_out)  carry_cnt++;
    if (borrow_out) borrow_cnt++;
  end

  // op: 0 up, 1 down, 2 load, 3 clear ; data {tens,units} ; expected {tens,units}
  localparam int NV = 17;
  localparam logic [17:0] VEC [NV] = '{
    {2'd0, 8'h00, 8'h01},  // R2
    {2'd0, 8'h00, 8'h02},  // R2
    {2'd2, 8'h58, 8'h58},  // R5
    {2'd0, 8'h00, 8'h59},  // R2
    {2'd0, 8'h00, 8'h00},  // R9 59 -> 00
    {2'd1, 8'h00, 8'h99},  // R3 R7 00 -> 99
    {2'd0, 8'h00, 8'h00},  // R7 99 -> 00
    {2'd2, 8'h19, 8'h19},  // R5
    {2'd0, 8'h00, 8'h20},  // R7
    {2'd1, 8'h00, 8'h19},  // R7
    {2'd2, 8'h0C, 8'h0C},  // R8
    {2'd0, 8'h00, 8'h10},  // R8
    {2'd2, 8'h0F, 8'h0F},  // R8
    {2'd1, 8'h00, 8'h0E},  // R8
    {2'd3, 8'h00, 8'h00},  // R6
    {2'd2, 8'h60, 8'h00},  // R9 via load
    {2'd2, 8'h61, 8'h61}   // R5
  };

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic do_op(input logic [1:0] op, input logic [7:0] data);
    @(negedge clk);
    case (op)
      2'd0: up_req = 1'b1;
      2'd1: dn_req = 1'b1;
      2'd2: begin load_n = 1'b0; {load_tens, load_units} = data; end
      default: clr = 1'b1;
    endcase
    @(negedge clk);
    up_req = 1'b0; dn_req = 1'b0; load_n = 1'b1; clr = 1'b0;
    settle();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset value", {tens, units}, 8'h00);
    check("R1 reset pulses", {6'd0, carry_out, borrow_out}, 8'h00);
    rst = 1'b0;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      do_op(VEC[i][17:16], VEC[i][15:8]);
      check($sformatf("vector %0d", i), {tens, units}, VEC[i][7:0]);
    end

    // R9: 61 down reaches the terminal value and clears
    do_op(2'd1, 8'h00);
    check("R9 61 down", {tens, units}, 8'h00);

    // R10: one carry_out pulse on 59 -> 00
    do_op(2'd2, 8'h59);
    carry_cnt = 0;
    do_op(2'd0, 8'h00);
    check("R10 carry_out on terminal", 8'(carry_cnt), 8'd1);

    // R10: one borrow_out pulse on 00 -> 99
    borrow_cnt = 0;
    do_op(2'd1, 8'h00);
    check("R10 borrow_out on 00 down", 8'(borrow_cnt), 8'd1);
    check("R10 value after borrow", {tens, units}, 8'h99);

    // R4: both strobes in the same cycle hold
    do_op(2'd2, 8'h34);
    @(negedge clk); up_req = 1'b1; dn_req = 1'b1;
    @(negedge clk); up_req = 1'b0; dn_req = 1'b0;
    settle();
    check("R4 simultaneous strobes", {tens, units}, 8'h34);

    // R4: a held strobe steps only once
    @(negedge clk); up_req = 1'b1;
    repeat (6) @(negedge clk);
    check("R4 held strobe", {tens, units}, 8'h35);
    up_req = 1'b0;
    settle();

    // R6: clear beats load
    @(negedge clk); clr = 1'b1; load_n = 1'b0; {load_tens, load_units} = 8'h47;
    @(negedge clk); clr = 1'b0; load_n = 1'b1;
    settle();
    check("R6 clear over load", {tens, units}, 8'h00);

    // R5: load beats an up strobe
    @(negedge clk); load_n = 1'b0; up_req = 1'b1; {load_tens, load_units} = 8'h33;
    @(negedge clk); load_n = 1'b1; up_req = 1'b0;
    settle();
    check("R5 load over count", {tens, units}, 8'h33);

    // R1: reset in mid-run
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check("R1 reset mid-run", {tens, units}, 8'h00);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule